// File: doc/BRIEF.md
# Translation Cache with Range-Invalidation Commands

This block is a small fully-associative translation cache for an I/O memory management unit, together with the decoder for the stage-1 invalidate-by-address commands that maintain it. Software-side logic fills entries through a plain write port. Each entry holds an address-space ID, a base address, an address mask, a granule code and a level hint. A combinational lookup port reports whether an address-space ID and address pair is covered by any valid entry.

Invalidation commands arrive as one 128-bit beat made of four 32-bit words, on a valid/ready stream. The decoder works out a page range from the granule, scale and count fields, and every matching entry is cleared on the clock edge that accepts the command. The consumer never applies back-pressure: ready is low only while reset is held, so a command is taken on any edge where valid is high and reset is released. A single page with a level hint skips the masked scan and removes only the entry whose key matches exactly.

Top module: `tlb_rinv_engine`

## Requirements
- R1: While rst_n is low, cmd_ready is low and every entry becomes invalid. Once reset is released, cmd_ready is high and lookups miss until entries are filled.
- R2: The opcode is cmd_data[7:0]. Opcode 0x12 invalidates by address within one address-space ID, taken from word 1 bits [31:16] (cmd_data[63:48]). Opcode 0x13 invalidates by address in every address space. Any other opcode is accepted and leaves the cache unchanged.
- R3: The granule code is word 2 bits [11:10] (cmd_data[75:74]). When it is 0, the count, scale and level fields are ignored, one page is assumed, and the range mask is 0xFFF.
- R4: When the granule code g is nonzero, the page count is (NUM+1)<<SCALE, with NUM in word 0 bits [16:12] and SCALE in word 0 bits [24:20]. The page size is 2^(2g+10) bytes, and the range mask is (pages << (2g+10)) - 1. The command address is {word 3, word 2 bits [31:12], 12'h000}.
- R5: An in-scope valid entry is cleared when the command address, with the entry's mask bits cleared, equals the entry base. In this case the entry covers the address.
- R6: An in-scope valid entry is also cleared when the entry base, with the range mask bits cleared, equals the command address. In this case the range covers the entry.
- R7: Under opcode 0x12, an entry is in scope only if its address-space ID equals the command's. Under opcode 0x13, every entry is in scope.
- R8: When the level field (word 2 bits [9:8]) is nonzero and the page count is exactly 1, the masked tests of R5 and R6 are not used. Instead, only an in-scope entry whose base, granule code and level all equal the command's is cleared.
- R9: A fill with fill_en high writes slot fill_idx and makes it valid from the next clock. If the same slot is invalidated on that edge, it ends invalid.
- R10: A lookup hits on a valid entry whose address-space ID equals lk_asid and whose base equals lk_addr with the entry's mask bits cleared. It returns the lowest-index such entry's index, base and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command beat present |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_data | input | 128 | Command words 0..3, word 0 in bits [31:0] |
| fill_en | input | 1 | Write one cache slot |
| fill_idx | input | 3 | Slot to write |
| fill_asid | input | 16 | Address-space ID for the slot |
| fill_base | input | 64 | Base address for the slot |
| fill_mask | input | 64 | Address mask (low ones) for the slot |
| fill_gran | input | 2 | Granule code for the slot |
| fill_level | input | 2 | Level hint for the slot |
| lk_asid | input | 16 | Lookup address-space ID |
| lk_addr | input | 64 | Lookup address |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_idx | output | 3 | Index of the lowest matching entry |
| lk_base | output | 64 | Base of the matching entry |
| lk_mask | output | 64 | Mask of the matching entry |

## Verification
The properties assume that fill masks are contiguous runs of low ones and that bases are aligned to their masks. They also assume that command addresses have their low twelve bits clear, which the command format forces. The bench draws bases from a 64-page window, aligned to masks of 4 KB, 64 KB or 2 MB. It draws command addresses, address-space IDs and small scale and count values from the same narrow window, so that the entry-covers-range and range-covers-entry cases both occur often. Directed cases add the exact-key path, unknown opcodes, a fill that collides with an invalidation, and overlapping entries for lookup priority.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
  localparam int ASID_W = 16;
  localparam int ADDR_W = 64;
  localparam int WORD_W = 32;
  localparam int CMD_W  = 4 * WORD_W;
  localparam int PAGE_SHIFT_MIN = 12;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] mask;
    logic [1:0]        gran;
    logic [1:0]        level;
  } tlb_entry_t;

  typedef struct packed {
    logic              known;
    logic              any_asid;
    logic              exact;
    logic [ASID_W-1:0] asid;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] rmask;
    logic [1:0]        tg;
    logic [1:0]        ttl;
  } inv_req_t;
endpackage

// File: rtl/tlbinv_decode.sv
module tlbinv_decode
  import tlbinv_pkg::*;
#(
  parameter logic [7:0] OP_SCOPED = 8'h12,
  parameter logic [7:0] OP_GLOBAL = 8'h13
) (
  input  logic [CMD_W-1:0] cmd,
  output inv_req_t         req
);
  logic [WORD_W-1:0] w0, w1, w2, w3;
  logic [7:0]        op;
  logic              tg_on;
  logic [4:0]        num_e, scale_e;
  logic [ADDR_W-1:0] pages;
  logic [5:0]        gshift;

  always_comb begin
    w0 = cmd[WORD_W-1:0];
    w1 = cmd[2*WORD_W-1:WORD_W];
    w2 = cmd[3*WORD_W-1:2*WORD_W];
    w3 = cmd[4*WORD_W-1:3*WORD_W];
    op = w0[7:0];
    tg_on   = (w2[11:10] != 2'd0);
    num_e   = tg_on ? w0[16:12] : 5'd0;
    scale_e = tg_on ? w0[24:20] : 5'd0;
    pages   = (ADDR_W'(num_e) + ADDR_W'(1)) << scale_e;
    gshift  = tg_on ? (6'({w2[11:10], 1'b0}) + 6'd10) : 6'(PAGE_SHIFT_MIN);
    req.known    = (op == OP_SCOPED) || (op == OP_GLOBAL);
    req.any_asid = (op == OP_GLOBAL);
    req.asid     = w1[31:16];
    req.addr     = {w3, w2[31:12], 12'h000};
    req.tg       = w2[11:10];
    req.ttl      = tg_on ? w2[9:8] : 2'd0;
    req.rmask    = (pages << gshift) - ADDR_W'(1);
    req.exact    = (req.ttl != 2'd0) && (pages == ADDR_W'(1));
  end
endmodule

// File: rtl/tlbinv_match.sv
module tlbinv_match
  import tlbinv_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  inv_req_t             req,
  input  tlb_entry_t           ent [ENTRIES],
  input  logic [ENTRIES-1:0]   vld,
  output logic [ENTRIES-1:0]   kill
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic scope_ok, covers_addr, covered_by, key_eq;
    always_comb begin
      scope_ok    = req.any_asid || (ent[i].asid == req.asid);
      covers_addr = ((req.addr & ~ent[i].mask) == ent[i].base);
      covered_by  = ((ent[i].base & ~req.rmask) == req.addr);
      key_eq      = (ent[i].base == req.addr) && (ent[i].gran == req.tg) &&
                    (ent[i].level == req.ttl);
      kill[i] = req.known && vld[i] && scope_ok &&
                (req.exact ? key_eq : (covers_addr || covered_by));
    end
  end
endmodule

// File: rtl/tlbinv_lookup.sv
module tlbinv_lookup
  import tlbinv_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  tlb_entry_t          ent [ENTRIES],
  input  logic [ENTRIES-1:0]  vld,
  input  logic [ASID_W-1:0]   asid,
  input  logic [ADDR_W-1:0]   addr,
  output logic                hit,
  output logic [IDX_W-1:0]    idx,
  output logic [ADDR_W-1:0]   base,
  output logic [ADDR_W-1:0]   mask
);
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    base = '0;
    mask = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vld[i] && (ent[i].asid == asid) && ((addr & ~ent[i].mask) == ent[i].base)) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        base = ent[i].base;
        mask = ent[i].mask;
      end
    end
  end
endmodule

// File: rtl/tlb_rinv_engine.sv
module tlb_rinv_engine
  import tlbinv_pkg::*;
#(
  parameter int         ENTRIES   = 8,
  parameter logic [7:0] OP_SCOPED = 8'h12,
  parameter logic [7:0] OP_GLOBAL = 8'h13,
  localparam int        IDX_W     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [CMD_W-1:0]   cmd_data,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [ASID_W-1:0]  fill_asid,
  input  logic [ADDR_W-1:0]  fill_base,
  input  logic [ADDR_W-1:0]  fill_mask,
  input  logic [1:0]         fill_gran,
  input  logic [1:0]         fill_level,
  input  logic [ASID_W-1:0]  lk_asid,
  input  logic [ADDR_W-1:0]  lk_addr,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [ADDR_W-1:0]  lk_base,
  output logic [ADDR_W-1:0]  lk_mask
);
  tlb_entry_t         ent_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] kill;
  inv_req_t           req;
  logic               fire;

  assign cmd_ready = rst_n;
  assign fire      = cmd_valid && cmd_ready;

  tlbinv_decode #(.OP_SCOPED(OP_SCOPED), .OP_GLOBAL(OP_GLOBAL)) u_dec (
    .cmd (cmd_data),
    .req (req)
  );

  tlbinv_match #(.ENTRIES(ENTRIES)) u_match (
    .req  (req),
    .ent  (ent_q),
    .vld  (valid_q),
    .kill (kill)
  );

  tlbinv_lookup #(.ENTRIES(ENTRIES)) u_lk (
    .ent  (ent_q),
    .vld  (valid_q),
    .asid (lk_asid),
    .addr (lk_addr),
    .hit  (lk_hit),
    .idx  (lk_idx),
    .base (lk_base),
    .mask (lk_mask)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic wr_here;
    assign wr_here = fill_en && (fill_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
      end else if (fire && kill[i]) begin
        valid_q[i] <= 1'b0;
      end else if (wr_here) begin
        valid_q[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_here) begin
        ent_q[i] <= '{asid: fill_asid, base: fill_base, mask: fill_mask,
                      gran: fill_gran, level: fill_level};
      end
    end
  end
endmodule

// File: rtl/tlbinv_checker.sv
module tlbinv_checker #(
  parameter int         ENTRIES   = 8,
  parameter logic [7:0] OP_SCOPED = 8'h12,
  parameter logic [7:0] OP_GLOBAL = 8'h13,
  localparam int        IDX_W     = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [7:0]         cmd_op,
  input logic               fill_en,
  input logic [IDX_W-1:0]   fill_idx,
  input logic [ENTRIES-1:0] valid_q,
  input logic               lk_hit,
  input logic [IDX_W-1:0]   lk_idx
);
  p_ready_in_reset_r1: assert property (@(posedge clk) !rst_n |-> !cmd_ready);
  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n) cmd_ready);
  p_reset_clears_r1: assert property (@(posedge clk) !rst_n |=> (valid_q == '0));

  p_unknown_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op != OP_SCOPED && cmd_op != OP_GLOBAL && !fill_en)
    |=> $stable(valid_q));

  p_fill_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !cmd_valid) |=> valid_q[$past(fill_idx)]);

  p_set_needs_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((valid_q & ~$past(valid_q)) != '0) |-> $past(fill_en));

  p_one_new_per_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_q & ~$past(valid_q)) <= 1);

  p_hit_is_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> valid_q[lk_idx]);
endmodule

bind tlb_rinv_engine tlbinv_checker #(
  .ENTRIES(ENTRIES), .OP_SCOPED(OP_SCOPED), .OP_GLOBAL(OP_GLOBAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_data[7:0]), .fill_en(fill_en), .fill_idx(fill_idx),
  .valid_q(valid_q), .lk_hit(lk_hit), .lk_idx(lk_idx)
);

// File: tb/sim_tlb_rinv_engine.sv
`timescale 1ns/1ps
module sim_tlb_rinv_engine;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [127:0] cmd_data = '0;
  logic fill_en = 0;
  logic [2:0] fill_idx = 0;
  logic [15:0] fill_asid = 0;
  logic [63:0] fill_base = 0, fill_mask = 0;
  logic [1:0] fill_gran = 0, fill_level = 0;
  logic [15:0] lk_asid = 0;
  logic [63:0] lk_addr = 0;
  logic lk_hit;
  logic [2:0] lk_idx;
  logic [63:0] lk_base, lk_mask;

  int errors = 0, checks = 0;
  bit m_v [N];
  logic [15:0] m_asid [N];
  logic [63:0] m_base [N], m_mask [N];
  logic [1:0] m_gran [N], m_lvl [N];

  always #10 clk = ~clk;

  tlb_rinv_engine u0 (.*);

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [127:0] mk_cmd(logic [7:0] op, logic [15:0] asid, logic [63:0] addr,
      logic [1:0] tg, logic [4:0] scale, logic [4:0] num, logic [1:0] ttl);
    logic [31:0] w0, w1, w2, w3;
    w0 = {7'd0, scale, 3'd0, num, 4'd0, op};
    w1 = {asid, 16'd0};
    w2 = {addr[31:12], tg, ttl, 8'd0};
    w3 = addr[63:32];
    return {w3, w2, w1, w0};
  endfunction

  // expected clear decision, from R2..R8
  function automatic bit exp_kill(int i, logic [127:0] c);
    logic [7:0] op; logic [1:0] tg, ttl; logic [63:0] pages, rmask, addr;
    int sh; bit scope;
    op = c[7:0]; tg = c[75:74];
    if (!m_v[i] || (op != 8'h12 && op != 8'h13)) return 0;
    addr = {c[127:96], c[95:76], 12'h0};
    if (tg == 0) begin pages = 1; sh = 12; ttl = 0; end
    else begin pages = (64'(c[16:12]) + 1) << c[24:20]; sh = 2*tg + 10; ttl = c[73:72]; end
    rmask = (pages << sh) - 1;
    scope = (op == 8'h13) || (m_asid[i] == c[63:48]);
    if (!scope) return 0;
    if (ttl != 0 && pages == 1)
      return (m_base[i] == addr) && (m_gran[i] == tg) && (m_lvl[i] == ttl);
    return ((addr & ~m_mask[i]) == m_base[i]) || ((m_base[i] & ~rmask) == addr);
  endfunction

  task automatic step(bit c_en, logic [127:0] c, bit f_en, int fi, logic [15:0] fa,
      logic [63:0] fb, logic [63:0] fm, logic [1:0] fg, logic [1:0] fl);
    bit k [N];
    @(negedge clk);
    cmd_valid = c_en; cmd_data = c;
    fill_en = f_en; fill_idx = 3'(fi); fill_asid = fa; fill_base = fb;
    fill_mask = fm; fill_gran = fg; fill_level = fl;
    for (int i = 0; i < N; i++) k[i] = c_en && exp_kill(i, c);
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (k[i]) m_v[i] = 0;
      else if (f_en && fi == i) begin
        m_v[i] = 1; m_asid[i] = fa; m_base[i] = fb; m_mask[i] = fm; m_gran[i] = fg; m_lvl[i] = fl;
      end
      if (f_en && fi == i) begin
        m_asid[i] = fa; m_base[i] = fb; m_mask[i] = fm; m_gran[i] = fg; m_lvl[i] = fl;
      end
    end
    @(negedge clk);
    cmd_valid = 0; fill_en = 0;
  endtask

  task automatic fill(int fi, logic [15:0] fa, logic [63:0] fb, logic [63:0] fm,
      logic [1:0] fg, logic [1:0] fl);
    step(0, '0, 1, fi, fa, fb, fm, fg, fl);
  endtask

  task automatic inv(logic [127:0] c);
    step(1, c, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic probe(string tag, logic [15:0] a, logic [63:0] ad);
    bit eh = 0; int ei = 0;
    lk_asid = a; lk_addr = ad;
    #1;
    for (int i = N - 1; i >= 0; i--)
      if (m_v[i] && m_asid[i] == a && ((ad & ~m_mask[i]) == m_base[i])) begin eh = 1; ei = i; end
    checks++;
    if (lk_hit !== eh || (eh && (lk_idx !== 3'(ei) || lk_base !== m_base[ei]))) begin
      errors++;
      $display("FAIL %s: asid=%0h addr=%0h actual hit=%0b idx=%0d base=%0h expected hit=%0b idx=%0d base=%0h",
        tag, a, ad, lk_hit, lk_idx, lk_base, eh, ei, eh ? m_base[ei] : 64'h0);
    end
  endtask

  task automatic probe_all(string tag);
    for (int i = 0; i < N; i++) if (m_v[i] || m_base[i] != 0) probe(tag, m_asid[i], m_base[i]);
  endtask

  task automatic expect_slot(string tag, int i, bit present);
    probe(tag, m_asid[i], m_base[i]);
    checks++;
    if (m_v[i] !== present) begin
      errors++;
      $display("FAIL %s: model slot %0d actual=%0b expected=%0b", tag, i, m_v[i], present);
    end
  endtask

  task automatic clear_all;
    inv(mk_cmd(8'h13, 0, 64'h0, 2'd3, 5'd31, 5'd31, 0));
  endtask

  function automatic logic [63:0] pick_mask(int s);
    case (s % 3) 0: return 64'hFFF; 1: return 64'hFFFF; default: return 64'h1FFFFF; endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_asid[i] = 0; m_base[i] = 0; m_mask[i] = 0; m_gran[i] = 0; m_lvl[i] = 0;
    end
    repeat (3) @(negedge clk);
    checks++;
    if (cmd_ready !== 1'b0) begin errors++; $display("FAIL R1: ready in reset actual=%0b expected=0", cmd_ready); end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (cmd_ready !== 1'b1) begin errors++; $display("FAIL R1: ready after reset actual=%0b expected=1", cmd_ready); end
    probe("R1 empty after reset", 16'h0, 64'h0);

    // R10 priority: overlapping entries
    fill(5, 16'h7, 64'h40000, 64'hFFFF, 1, 0);
    fill(2, 16'h7, 64'h40000, 64'hFFF, 1, 0);
    probe("R10 lowest index wins", 16'h7, 64'h40000);
    probe("R10 wider entry only", 16'h7, 64'h4A000);
    probe("R10 asid mismatch misses", 16'h8, 64'h40000);

    // R2 unknown opcode ignored
    inv(mk_cmd(8'h20, 16'h7, 64'h40000, 0, 0, 0, 0));
    expect_slot("R2 unknown opcode keeps slot 2", 2, 1);
    expect_slot("R2 unknown opcode keeps slot 5", 5, 1);

    // R7 scope: scoped op with other asid leaves entries
    inv(mk_cmd(8'h12, 16'h9, 64'h40000, 0, 0, 0, 0));
    expect_slot("R7 other asid untouched", 2, 1);

    // R3 TG=0 ignores scale/num: only entries covering 0x40000 (R5)
    fill(3, 16'h7, 64'h48000, 64'hFFF, 0, 0);
    inv(mk_cmd(8'h12, 16'h7, 64'h40000, 0, 5'd4, 5'd7, 2'd1));
    expect_slot("R3 tg0 range stays one page (slot3)", 3, 1);
    expect_slot("R5 entry covering address cleared", 5, 0);
    expect_slot("R5 exact page entry cleared", 2, 0);

    // R4/R6 range covers entries: 16 pages of 4K from 0x40000
    fill(0, 16'h1, 64'h4F000, 64'hFFF, 1, 0);
    fill(1, 16'h2, 64'h50000, 64'hFFF, 1, 0);
    inv(mk_cmd(8'h13, 16'h0, 64'h40000, 2'd1, 5'd2, 5'd3, 0));
    expect_slot("R4 R6 last page inside range cleared", 0, 0);
    expect_slot("R4 first page past range kept", 1, 1);
    expect_slot("R6 R7 global op clears asid 7", 3, 0);

    // R4 granule 64K (tg=3 -> shift 16), one page
    fill(4, 16'h2, 64'h5F000, 64'hFFF, 1, 0);
    inv(mk_cmd(8'h12, 16'h2, 64'h50000, 2'd3, 0, 0, 0));
    expect_slot("R4 64K granule covers 0x5F000", 4, 0);
    expect_slot("R4 64K granule covers base", 1, 0);

    // R8 exact key path
    fill(6, 16'h3, 64'h60000, 64'hFFF, 1, 2);
    fill(7, 16'h3, 64'h60000, 64'hFFFF, 1, 1);
    inv(mk_cmd(8'h12, 16'h3, 64'h60000, 2'd1, 0, 0, 2'd2));
    expect_slot("R8 exact key removed", 6, 0);
    expect_slot("R8 level mismatch kept despite cover", 7, 1);

    // R9 fill colliding with invalidation
    step(1, mk_cmd(8'h12, 16'h3, 64'h60000, 0, 0, 0, 0), 1, 7, 16'h3, 64'h60000, 64'hFFF, 1, 0);
    expect_slot("R9 invalidation wins over fill", 7, 0);
    fill(7, 16'h3, 64'h61000, 64'hFFF, 1, 0);
    expect_slot("R9 fill visible next cycle", 7, 1);

    // random mix
    clear_all;
    probe_all("R2 global wide clear");
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom % 4;
      if (sel < 2) begin
        logic [63:0] mk = pick_mask($urandom);
        logic [63:0] b = (64'($urandom % 64) << 12) & ~mk;
        fill($urandom % N, 16'($urandom % 3), b, mk, 2'($urandom), 2'($urandom));
      end else begin
        logic [7:0] op = (sel == 2) ? 8'h12 : (($urandom % 8 == 0) ? 8'h44 : 8'h13);
        inv(mk_cmd(op, 16'($urandom % 3), 64'($urandom % 64) << 12, 2'($urandom),
                   5'($urandom % 4), 5'($urandom % 4), 2'($urandom)));
      end
      probe_all("R5 R6 R7 R8 R10 random");
      probe("R10 random address", 16'($urandom % 3), 64'($urandom % 64) << 12);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule